// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This core runs programs in which no instruction names a register. All working data sits in a small internal push-down stack. Code and data share one byte-wide synchronous memory. A program counter starts at address zero and steps through the code. Each opcode fetch and each operand byte takes one cycle.

Two instructions move data, and each is four bytes long: a one-byte opcode followed by a 24-bit byte address. A load copies a 32-bit word from that address onto the stack. A store writes the top word back to that address and removes it from the stack. Arithmetic instructions are a single opcode byte. They take the top two stack entries and put one result in their place. Expressions are written in postfix order, for example `(B + C) * D - E` becomes load, load, add, load, multiply, load, subtract, store.

A stop opcode, an unknown opcode or a stack fault halts the core. A halted core stays quiet until the next reset. Two sticky flags tell an over-full stack apart from a stack with too few entries.

Top module: `stk_core`

## Requirements
- R1: While `rst_n` is low, and for the cycles the internal release takes, the core makes no memory access and `halted`, `err_ovf` and `err_unf` are low. The first access after release is a read at address 0.
- R2: Opcode 0x10 (load) is followed by three address bytes, most significant first. It reads four bytes at that address and the following three, in little-endian order, and pushes the 32-bit word.
- R3: Opcode 0x11 (store) is followed by three address bytes, most significant first. It writes the top word to that address and the following three in ascending order, least significant byte first, then removes the word from the stack.
- R4: Opcode 0x20 adds, 0x21 subtracts the top entry from the entry below it, and 0x22 keeps the low 32 bits of the product. All results wrap modulo 2^32, and the two operands are replaced by the one result.
- R5: The program counter starts at 0. It advances by 4 after a load or store and by 1 after an arithmetic opcode. The stack returns words in last-in first-out order and holds 16 words.
- R6: Counted from the cycle of its opcode read, a load takes 11 cycles, a store 10, an arithmetic opcode 2. A stop, unknown or faulting opcode raises `halted` 2 cycles after its opcode read.
- R7: Opcode 0xFF, and every code not listed in R2 to R4, halts the core without raising a flag. Once `halted` is high it stays high, and no read or write is made until reset.
- R8: A load issued while 16 words are held raises `err_ovf` and halts. No address or data bytes are fetched for it.
- R9: A store issued with an empty stack, or an arithmetic opcode issued with fewer than two words held, raises `err_unf` and halts.
- R10: An error flag, once raised, stays high until reset. The two flags are never high together.
- R11: A read and a write never occur in the same cycle. Read data is taken in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| mem_addr | output | 24 | Byte address of the current memory access |
| mem_rd | output | 1 | Read request; data is expected on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte returned by memory for the previous cycle's read |
| halted | output | 1 | High once the core has stopped |
| err_ovf | output | 1 | Sticky flag: a load found the stack full |
| err_unf | output | 1 | Sticky flag: a store or arithmetic opcode found too few entries |

## Verification
The hardest condition to reach from the ports is a completely full stack. The program must push sixteen words, and then either fold them all with fifteen arithmetic opcodes or issue one more push. Both programs are built by generating the code bytes in loops. The first checks the deepest entry through the final sum. The second shows, from the cycle count, that the faulting load fetched no operand bytes. Underflow is reached in two ways: a store on an empty stack, and an arithmetic opcode with a single entry.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_LOAD  = 8'h10;
  localparam logic [BYTE_W-1:0] OPC_STORE = 8'h11;
  localparam logic [BYTE_W-1:0] OPC_ADD   = 8'h20;
  localparam logic [BYTE_W-1:0] OPC_SUB   = 8'h21;
  localparam logic [BYTE_W-1:0] OPC_MUL   = 8'h22;
  localparam logic [BYTE_W-1:0] OPC_STOP  = 8'hFF;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_MUL
  } alu_op_e;

  typedef enum logic [1:0] {
    STK_IDLE,
    STK_PUSH,
    STK_POP,
    STK_FOLD
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_OPREQ,
    ST_OPDEC,
    ST_ADDR,
    ST_LOAD,
    ST_STORE,
    ST_HALT
  } state_e;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] sos,
  input  logic [DATA_W-1:0] tos,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    unique case (op)
      ALU_SUB: res = sos - tos;
      ALU_MUL: res = sos * tos;
      default: res = sos + tos;
    endcase
  end

endmodule

// File: rtl/stk_lifo.sv
module stk_lifo
  import stk_pkg::*;
#(
  parameter  int unsigned DATA_W = 32,
  parameter  int unsigned DEPTH  = 16,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] tos,
  output logic [DATA_W-1:0] sos,
  output logic [CNT_W-1:0]  count
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  top_idx, sec_idx, wr_idx;
  logic              wr_en;
  logic [DATA_W-1:0] rd_arr [DEPTH];

  always_comb begin
    top_idx = IDX_W'(cnt_q - CNT_W'(1));
    sec_idx = IDX_W'(cnt_q - CNT_W'(2));
    wr_en   = 1'b0;
    wr_idx  = IDX_W'(cnt_q);
    cnt_d   = cnt_q;
    unique case (op)
      STK_PUSH: begin
        wr_en = 1'b1;
        cnt_d = cnt_q + CNT_W'(1);
      end
      STK_POP: cnt_d = cnt_q - CNT_W'(1);
      STK_FOLD: begin
        wr_en  = 1'b1;
        wr_idx = sec_idx;
        cnt_d  = cnt_q - CNT_W'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) q <= wdata;
    end
    assign rd_arr[g] = q;
  end

  assign tos   = rd_arr[top_idx];
  assign sos   = rd_arr[sec_idx];
  assign count = cnt_q;

  // R8: the sequencer must never push onto a full stack
  a_r8_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_PUSH) |-> (cnt_q < CNT_W'(DEPTH)));
  // R9: removal only with a word present
  a_r9_pop_has_word: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_POP) |-> (cnt_q != '0));
  // R9: folding needs two operands
  a_r9_fold_has_two: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_FOLD) |-> (cnt_q >= CNT_W'(2)));
  // R5: occupancy never exceeds the depth
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              halted,
  output logic              err_ovf,
  output logic              err_unf
);

  localparam int unsigned ABYTES = ADDR_W / BYTE_W;
  localparam int unsigned NBYTES = DATA_W / BYTE_W;
  localparam int unsigned MAXB   = (ABYTES > NBYTES) ? ABYTES : NBYTES;
  localparam int unsigned IDX_W  = $clog2(MAXB + 1);
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] LONG_STEP  = ADDR_W'(ABYTES + 1);
  localparam logic [ADDR_W-1:0] SHORT_STEP = ADDR_W'(1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [7:0]        opc_q, opc_d;
  logic [ADDR_W-1:0] oaddr_q, oaddr_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              ovf_q, ovf_d, unf_q, unf_d;

  stk_op_e           stk_op;
  logic [DATA_W-1:0] stk_wdata, stk_tos, stk_sos, alu_res;
  logic [CNT_W-1:0]  stk_cnt;
  alu_op_e           alu_op;

  stk_lifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_lifo (
    .clk   (clk),
    .rst_n (rst_i_n),
    .op    (stk_op),
    .wdata (stk_wdata),
    .tos   (stk_tos),
    .sos   (stk_sos),
    .count (stk_cnt)
  );

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (alu_op),
    .sos (stk_sos),
    .tos (stk_tos),
    .res (alu_res)
  );

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    opc_d     = opc_q;
    oaddr_d   = oaddr_q;
    word_d    = word_q;
    idx_d     = idx_q;
    ovf_d     = ovf_q;
    unf_d     = unf_q;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = '0;
    stk_op    = STK_IDLE;
    stk_wdata = alu_res;
    alu_op    = ALU_ADD;
    unique case (state_q)
      ST_BOOT: state_d = ST_OPREQ;
      ST_OPREQ: begin
        mem_rd  = 1'b1;
        state_d = ST_OPDEC;
      end
      ST_OPDEC: begin
        opc_d = mem_rdata;
        idx_d = '0;
        if (mem_rdata == OPC_LOAD) begin
          if (stk_cnt == CNT_W'(DEPTH)) begin
            ovf_d   = 1'b1;
            state_d = ST_HALT;
          end else begin
            state_d = ST_ADDR;
          end
        end else if (mem_rdata == OPC_STORE) begin
          if (stk_cnt == '0) begin
            unf_d   = 1'b1;
            state_d = ST_HALT;
          end else begin
            state_d = ST_ADDR;
          end
        end else if ((mem_rdata == OPC_ADD) || (mem_rdata == OPC_SUB) ||
                     (mem_rdata == OPC_MUL)) begin
          if (stk_cnt < CNT_W'(2)) begin
            unf_d   = 1'b1;
            state_d = ST_HALT;
          end else begin
            if (mem_rdata == OPC_SUB)      alu_op = ALU_SUB;
            else if (mem_rdata == OPC_MUL) alu_op = ALU_MUL;
            stk_op  = STK_FOLD;
            pc_d    = pc_q + SHORT_STEP;
            state_d = ST_OPREQ;
          end
        end else begin
          state_d = ST_HALT;
        end
      end
      ST_ADDR: begin
        if (idx_q < IDX_W'(ABYTES)) begin
          mem_rd   = 1'b1;
          mem_addr = pc_q + ADDR_W'(idx_q) + SHORT_STEP;
        end
        if (idx_q != '0) oaddr_d = {oaddr_q[ADDR_W-BYTE_W-1:0], mem_rdata};
        if (idx_q == IDX_W'(ABYTES)) begin
          idx_d   = '0;
          state_d = (opc_q == OPC_LOAD) ? ST_LOAD : ST_STORE;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_LOAD: begin
        if (idx_q < IDX_W'(NBYTES)) begin
          mem_rd   = 1'b1;
          mem_addr = oaddr_q + ADDR_W'(idx_q);
        end
        if (idx_q != '0) word_d = {mem_rdata, word_q[DATA_W-1:BYTE_W]};
        if (idx_q == IDX_W'(NBYTES)) begin
          stk_op    = STK_PUSH;
          stk_wdata = word_d;
          pc_d      = pc_q + LONG_STEP;
          state_d   = ST_OPREQ;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_STORE: begin
        mem_wr    = 1'b1;
        mem_addr  = oaddr_q + ADDR_W'(idx_q);
        mem_wdata = 8'(stk_tos >> {idx_q, 3'b000});
        if (idx_q == IDX_W'(NBYTES - 1)) begin
          stk_op  = STK_POP;
          pc_d    = pc_q + LONG_STEP;
          state_d = ST_OPREQ;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_BOOT;
      pc_q    <= '0;
      opc_q   <= '0;
      oaddr_q <= '0;
      word_q  <= '0;
      idx_q   <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      opc_q   <= opc_d;
      oaddr_q <= oaddr_d;
      word_q  <= word_d;
      idx_q   <= idx_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
    end
  end

  assign halted  = (state_q == ST_HALT);
  assign err_ovf = ovf_q;
  assign err_unf = unf_q;

  // R11: port direction is exclusive per cycle
  a_r11_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(mem_rd && mem_wr));
  // R7: a stopped core is silent on the memory port
  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    halted |-> (!mem_rd && !mem_wr));
  // R7: stop is final until reset
  a_r7_halt_stays: assert property (@(posedge clk) disable iff (!rst_i_n)
    halted |=> halted);
  // R10: flags hold
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_ovf |=> err_ovf);
  a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_unf |=> err_unf);
  // R10: at most one fault is reported
  a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(err_ovf && err_unf));
  // R8, R9: every fault stops the core
  a_r9_fault_halts: assert property (@(posedge clk) disable iff (!rst_i_n)
    (err_ovf || err_unf) |-> halted);

endmodule

// File: tb/stk_core_tb.sv
module stk_core_tb;

  localparam int MEMSZ = 4096;

  logic        clk;
  logic        rst_n;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        halted, err_ovf, err_unf;

  logic [7:0] mem [MEMSZ];
  logic [7:0] img [MEMSZ];

  int n_chk  = 0;
  int n_fail = 0;

  int   exp_cyc;
  bit   exp_ovf, exp_unf;
  int   exp_wa[$];
  logic [7:0] exp_wd[$];
  int   bp;

  stk_core u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted),
    .err_ovf   (err_ovf),
    .err_unf   (err_unf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // synchronous byte memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // every-clock comparison of the write stream and port rules
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd && mem_wr) chk(0, "R11", "read and write together", 1, 0);
      if (halted) chk(!mem_rd && !mem_wr, "R7", "access while halted",
                      {mem_rd, mem_wr}, 0);
      if (mem_wr) begin
        if (exp_wr_empty()) begin
          chk(0, "R3", "unexpected write addr", mem_addr, 0);
        end else begin
          int   ea;
          logic [7:0] ed;
          ea = exp_wa.pop_front();
          ed = exp_wd.pop_front();
          chk(int'(mem_addr) == ea, "R3", "write address", mem_addr, ea);
          chk(mem_wdata == ed, "R3", "write byte", mem_wdata, ed);
        end
      end
    end
  end

  function automatic bit exp_wr_empty();
    return exp_wa.size() == 0;
  endfunction

  function automatic logic [31:0] rd_word(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
    bp = 0;
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int i = 0; i < 4; i++) mem[a+i] = w[8*i +: 8];
  endtask

  task automatic emit1(input logic [7:0] op);
    mem[bp] = op;
    bp++;
  endtask

  task automatic emit4(input logic [7:0] op, input int a);
    mem[bp]   = op;
    mem[bp+1] = 8'(a >> 16);
    mem[bp+2] = 8'(a >> 8);
    mem[bp+3] = 8'(a);
    bp += 4;
  endtask

  // behavioural interpreter built from the requirements
  task automatic model();
    logic [31:0] stk[$];
    int  p;
    bit  done;
    p = 0;
    done = 0;
    exp_cyc = 0; exp_ovf = 0; exp_unf = 0;
    exp_wa.delete(); exp_wd.delete();
    for (int i = 0; i < MEMSZ; i++) img[i] = mem[i];
    for (int n = 0; n < 500 && !done; n++) begin
      logic [7:0]  op;
      int          a;
      logic [31:0] t, s, w;
      op = img[p];
      a  = {8'h00, img[(p+1)%MEMSZ], img[(p+2)%MEMSZ], img[(p+3)%MEMSZ]};
      if (op == 8'h10) begin
        if (stk.size() == 16) begin
          exp_ovf = 1; exp_cyc += 2; done = 1;
        end else begin
          w = {img[a+3], img[a+2], img[a+1], img[a]};
          stk.push_back(w);
          exp_cyc += 11; p += 4;
        end
      end else if (op == 8'h11) begin
        if (stk.size() == 0) begin
          exp_unf = 1; exp_cyc += 2; done = 1;
        end else begin
          w = stk.pop_back();
          for (int i = 0; i < 4; i++) begin
            img[a+i] = w[8*i +: 8];
            exp_wa.push_back(a + i);
            exp_wd.push_back(w[8*i +: 8]);
          end
          exp_cyc += 10; p += 4;
        end
      end else if (op == 8'h20 || op == 8'h21 || op == 8'h22) begin
        if (stk.size() < 2) begin
          exp_unf = 1; exp_cyc += 2; done = 1;
        end else begin
          t = stk.pop_back();
          s = stk.pop_back();
          if (op == 8'h20)      stk.push_back(s + t);
          else if (op == 8'h21) stk.push_back(s - t);
          else                  stk.push_back(s * t);
          exp_cyc += 2; p += 1;
        end
      end else begin
        exp_cyc += 2; done = 1;
      end
    end
  endtask

  task automatic run(input string name);
    int  cyc;
    bit  started;
    int  mism;
    model();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!halted && !err_ovf && !err_unf, "R1", {name, " reset outputs"},
        {halted, err_ovf, err_unf}, 0);
    chk(!mem_rd && !mem_wr, "R1", {name, " quiet in reset"}, {mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    cyc = 0;
    started = 0;
    while (!halted && cyc < 5000) begin
      @(negedge clk);
      if (!started && (mem_rd || mem_wr)) begin
        started = 1;
        chk(mem_rd && mem_addr == 24'h0, "R1", {name, " first access"}, mem_addr, 0);
      end
      if (started && !halted) cyc++;
    end
    chk(halted, "R7", {name, " reached halt"}, halted, 1);
    chk(cyc == exp_cyc, "R6", {name, " cycles to halt"}, cyc, exp_cyc);
    chk(err_ovf == exp_ovf, "R8", {name, " overflow flag"}, err_ovf, exp_ovf);
    chk(err_unf == exp_unf, "R9", {name, " underflow flag"}, err_unf, exp_unf);
    repeat (5) @(negedge clk);
    chk(halted && err_ovf == exp_ovf && err_unf == exp_unf, "R10",
        {name, " state held"}, {halted, err_ovf, err_unf}, {1'b1, exp_ovf, exp_unf});
    chk(exp_wa.size() == 0, "R3", {name, " missing writes"}, exp_wa.size(), 0);
    mism = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== img[i]) mism++;
    chk(mism == 0, "R2", {name, " memory image"}, mism, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    mem_rdata = 8'h00;

    // reference expression A = (B + C) * D - E, 23 bytes of code (R2 R4 R5)
    clear_mem();
    put_word(24'h100, 7); put_word(24'h104, 5);
    put_word(24'h108, 3); put_word(24'h10C, 4);
    emit4(8'h10, 24'h100); emit4(8'h10, 24'h104); emit1(8'h20);
    emit4(8'h10, 24'h108); emit1(8'h22);
    emit4(8'h10, 24'h10C); emit1(8'h21);
    emit4(8'h11, 24'h110);
    chk(bp == 23, "R5", "reference code length", bp, 23);
    emit1(8'hFF);
    run("expr");
    chk(rd_word(24'h110) == 32, "R4", "expression result", rd_word(24'h110), 32);

    // wrap, order and product cases (R4 R5)
    clear_mem();
    put_word(24'h200, 3); put_word(24'h204, 5);
    put_word(24'h208, 32'hFFFF_FFFF); put_word(24'h20C, 2);
    put_word(24'h210, 32'h1234_5678); put_word(24'h214, 32'h9ABC_DEF0);
    emit4(8'h10, 24'h200); emit4(8'h10, 24'h204); emit1(8'h21); emit4(8'h11, 24'h300);
    emit4(8'h10, 24'h208); emit4(8'h10, 24'h20C); emit1(8'h20); emit4(8'h11, 24'h304);
    emit4(8'h10, 24'h210); emit4(8'h10, 24'h214); emit1(8'h22); emit4(8'h11, 24'h308);
    emit4(8'h10, 24'h200); emit4(8'h10, 24'h204);
    emit4(8'h11, 24'h30C); emit4(8'h11, 24'h310);
    emit1(8'hFF);
    run("arith");
    chk(rd_word(24'h300) == 32'hFFFF_FFFE, "R4", "sub below zero",
        rd_word(24'h300), 32'hFFFF_FFFE);
    chk(rd_word(24'h304) == 32'h1, "R4", "add wrap", rd_word(24'h304), 1);
    chk(rd_word(24'h308) == 32'h242D_2080, "R4", "product low bits",
        rd_word(24'h308), 32'h242D_2080);
    chk(rd_word(24'h30C) == 5 && rd_word(24'h310) == 3, "R5", "lifo order",
        {rd_word(24'h30C), rd_word(24'h310)}, {32'd5, 32'd3});

    // full stack folded: sixteen loads, fifteen adds (R5)
    clear_mem();
    for (int i = 0; i < 16; i++) put_word(24'h400 + 4*i, i + 1);
    for (int i = 0; i < 16; i++) emit4(8'h10, 24'h400 + 4*i);
    for (int i = 0; i < 15; i++) emit1(8'h20);
    emit4(8'h11, 24'h500);
    emit1(8'hFF);
    run("deep");
    chk(rd_word(24'h500) == 136, "R5", "sixteen-deep sum", rd_word(24'h500), 136);

    // seventeenth load overflows (R8)
    clear_mem();
    for (int i = 0; i < 17; i++) emit4(8'h10, 24'h600);
    emit1(8'hFF);
    run("overflow");
    chk(err_ovf && !err_unf, "R8", "overflow only", {err_ovf, err_unf}, 2'b10);

    // store on empty stack (R9)
    clear_mem();
    emit4(8'h11, 24'h700);
    emit1(8'hFF);
    run("store-empty");
    chk(!err_ovf && err_unf, "R9", "underflow only", {err_ovf, err_unf}, 2'b01);

    // arithmetic with a single entry (R9)
    clear_mem();
    emit4(8'h10, 24'h700);
    emit1(8'h22);
    emit1(8'hFF);
    run("arith-one");

    // unlisted opcode stops without a flag (R7)
    clear_mem();
    put_word(24'h800, 32'hA5A5_0101);
    emit4(8'h10, 24'h800);
    emit1(8'h33);
    emit4(8'h11, 24'h804);
    emit1(8'hFF);
    run("unknown");
    chk(rd_word(24'h804) == 0, "R7", "nothing after unknown opcode",
        rd_word(24'h804), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule